// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides, for each I/O or memory request seen on either side of a PCI-to-PCI bridge, whether the request crosses the bridge. It holds three address windows: an I/O window, a memory-mapped I/O window and a prefetchable memory window that can reach above 4 GB. It also holds three control bits that change the decision: ISA alias exclusion, legacy VGA forwarding and VGA palette write snooping. Configuration is loaded through a simple write port made of a register select, a write enable and 32 data bits.

A request is one cycle with `reqValid` high, carrying a 64-bit address, a command class, a write flag and the side it came from. One clock edge later the block shows the decision on `fwdDown` or `fwdUp`. A request from the primary side that something claims goes downstream. A request from the secondary side goes upstream only when nothing claims it. Data movement, buffering and bus handshakes are handled elsewhere.

Top module: `pci_window_decode`

## Requirements
- R1: After reset, `fwdDown` and `fwdUp` are low. All three windows are empty and all control bits are clear, so no request is claimed. A primary request is then never forwarded, and a secondary I/O or memory request always goes upstream.
- R2: Each decision is registered. The outputs show the result for the request sampled at the previous rising edge. Both outputs are low after a cycle without `reqValid`, and after a request of class 0 or 3 (`reqKind`: 1 = I/O, 2 = memory).
- R3: I/O window. Select 0 sets base address bits [15:12] from data [7:4] and limit bits [15:12] from data [15:12]; data [3:0] and [11:8] are ignored. Select 1 sets base bits [31:16] from data [15:0] and limit bits [31:16] from data [31:16]. The low 12 base bits count as 000h and the low 12 limit bits as FFFh. An I/O request matches when address bits [63:32] are zero and address [31:0] lies between base and limit, both ends included.
- R4: Memory window. Select 2 sets base bits [31:20] from data [15:4] and limit bits [31:20] from data [31:20]. The granularity is 1 MB. Only memory requests with address bits [63:32] zero can match.
- R5: Prefetchable window. Select 3 sets the low parts, in the same layout as select 2. Select 4 sets base bits [63:32] and select 5 sets limit bits [63:32]. Memory requests are compared over the full 64-bit address, so the window can sit above 4 GB.
- R6: A window whose limit is below its base matches nothing.
- R7: With ISA exclusion set (select 6, data bit 0), an I/O address below 10000h whose bits [9:8] are not 00 is not claimed by the I/O window. Such an address therefore goes upstream from the secondary side and is not forwarded from the primary side. I/O addresses at 10000h and above are not affected.
- R8: With VGA forwarding set (select 6, data bit 1), these requests are claimed: memory A0000h to BFFFFh, and I/O addresses below 10000h whose bits [9:0] fall in 3B0h–3BBh or 3C0h–3DFh. The VGA claim takes precedence over the ISA exclusion.
- R9: With palette snoop set (select 6, data bit 2), I/O writes below 10000h whose bits [9:0] are 3C6h, 3C8h or 3C9h are claimed. Reads to the same addresses are not claimed by the snoop.
- R10: `fwdDown` is raised only for claimed requests from the primary side (`fromSec` = 0). `fwdUp` is raised only for unclaimed requests from the secondary side. The two outputs are never high together.
- R11: A configuration write in the same cycle as a request takes effect for later requests only. The request in that cycle is decided on the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration register select |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 64 | Request address |
| reqKind | input | 2 | Command class: 1 I/O, 2 memory, others none |
| reqWrite | input | 1 | Request is a write |
| fromSec | input | 1 | Request came from the secondary side |
| fwdDown | output | 1 | Forward toward secondary |
| fwdUp | output | 1 | Forward toward primary |

## Verification
A configuration write and a request can arrive in the same cycle, and the request must be decided on the settings from before that write. The bench produces this directed case by raising the memory window write and a request inside the new window together. The expected result comes from the model state from before the write, and a second request checks the new state. Within a single request, several claims can also overlap: ISA exclusion against VGA I/O, and VGA I/O against palette snoop. The bench compares these overlaps with a reference function.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  typedef enum logic [2:0] {
    SEL_IO_LO      = 3'd0,
    SEL_IO_HI      = 3'd1,
    SEL_MEM        = 3'd2,
    SEL_PF         = 3'd3,
    SEL_PF_BASE_UP = 3'd4,
    SEL_PF_LIM_UP  = 3'd5,
    SEL_CTRL       = 3'd6
  } cfgSel_e;

  localparam logic [1:0] KIND_IO  = 2'd1;
  localparam logic [1:0] KIND_MEM = 2'd2;

  typedef struct packed {
    logic wrIoLo;
    logic wrIoHi;
    logic wrMem;
    logic wrPf;
    logic wrPfBaseUp;
    logic wrPfLimUp;
    logic wrCtrl;
    logic reqLoad;
    logic isIo;
    logic isMem;
  } strobe_t;

endpackage

// File: rtl/pwd_range.sv
module pwd_range #(
  parameter int W = 20
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] val,
  output logic         hit
);
  // Inclusive compare; hi < lo yields no hit naturally.
  assign hit = (val >= lo) && (val <= hi);
endmodule

// File: rtl/pwd_ctrl.sv
module pwd_ctrl
  import pwd_pkg::*;
(
  input  logic       cfgWrEn,
  input  logic [2:0] cfgSel,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output strobe_t    strobes
);
  always_comb begin
    strobes            = '0;
    strobes.wrIoLo     = cfgWrEn && (cfgSel == SEL_IO_LO);
    strobes.wrIoHi     = cfgWrEn && (cfgSel == SEL_IO_HI);
    strobes.wrMem      = cfgWrEn && (cfgSel == SEL_MEM);
    strobes.wrPf       = cfgWrEn && (cfgSel == SEL_PF);
    strobes.wrPfBaseUp = cfgWrEn && (cfgSel == SEL_PF_BASE_UP);
    strobes.wrPfLimUp  = cfgWrEn && (cfgSel == SEL_PF_LIM_UP);
    strobes.wrCtrl     = cfgWrEn && (cfgSel == SEL_CTRL);
    strobes.reqLoad    = reqValid;
    strobes.isIo       = (reqKind == KIND_IO);
    strobes.isMem      = (reqKind == KIND_MEM);
  end
endmodule

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int IO_W     = 32,
  parameter int MEM_W    = 32,
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              fromSec,
  output logic              fwdDown,
  output logic              fwdUp
);
  localparam int IO_NIB_W  = 16 - IO_GRAN;
  localparam int IO_UP_W   = IO_W - 16;
  localparam int IO_CMP_W  = IO_W - IO_GRAN;
  localparam int MEM_FLD_W = MEM_W - MEM_GRAN;
  localparam int PF_UP_W   = ADDR_W - MEM_W;
  localparam int PF_CMP_W  = ADDR_W - MEM_GRAN;
  localparam int ISA_SPACE = 16;
  localparam int ALIAS_W   = 10;

  logic [IO_NIB_W-1:0]  ioBaseLo, ioLimLo;
  logic [IO_UP_W-1:0]   ioBaseHi, ioLimHi;
  logic [MEM_FLD_W-1:0] memBase, memLim, pfBase, pfLim;
  logic [PF_UP_W-1:0]   pfBaseUp, pfLimUp;
  logic                 isaEn, vgaEn, vgaSnoop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioBaseLo <= '1; ioLimLo <= '0;
      ioBaseHi <= '1; ioLimHi <= '0;
      memBase  <= '1; memLim  <= '0;
      pfBase   <= '1; pfLim   <= '0;
      pfBaseUp <= '1; pfLimUp <= '0;
      isaEn    <= 1'b0;
      vgaEn    <= 1'b0;
      vgaSnoop <= 1'b0;
    end else begin
      if (strobes.wrIoLo) begin
        ioBaseLo <= cfgWrData[IO_GRAN-8 +: IO_NIB_W];
        ioLimLo  <= cfgWrData[IO_GRAN   +: IO_NIB_W];
      end
      if (strobes.wrIoHi) begin
        ioBaseHi <= cfgWrData[0  +: IO_UP_W];
        ioLimHi  <= cfgWrData[16 +: IO_UP_W];
      end
      if (strobes.wrMem) begin
        memBase <= cfgWrData[MEM_GRAN-16 +: MEM_FLD_W];
        memLim  <= cfgWrData[MEM_GRAN    +: MEM_FLD_W];
      end
      if (strobes.wrPf) begin
        pfBase <= cfgWrData[MEM_GRAN-16 +: MEM_FLD_W];
        pfLim  <= cfgWrData[MEM_GRAN    +: MEM_FLD_W];
      end
      if (strobes.wrPfBaseUp) pfBaseUp <= cfgWrData[PF_UP_W-1:0];
      if (strobes.wrPfLimUp)  pfLimUp  <= cfgWrData[PF_UP_W-1:0];
      if (strobes.wrCtrl) begin
        isaEn    <= cfgWrData[0];
        vgaEn    <= cfgWrData[1];
        vgaSnoop <= cfgWrData[2];
      end
    end
  end

  // Window compares
  logic ioInRange, memInRange, pfInRange;

  pwd_range #(.W(IO_CMP_W)) u_ioRange (
    .lo ({ioBaseHi, ioBaseLo}),
    .hi ({ioLimHi, ioLimLo}),
    .val(reqAddr[IO_W-1:IO_GRAN]),
    .hit(ioInRange)
  );

  pwd_range #(.W(MEM_FLD_W)) u_memRange (
    .lo (memBase),
    .hi (memLim),
    .val(reqAddr[MEM_W-1:MEM_GRAN]),
    .hit(memInRange)
  );

  pwd_range #(.W(PF_CMP_W)) u_pfRange (
    .lo ({pfBaseUp, pfBase}),
    .hi ({pfLimUp, pfLim}),
    .val(reqAddr[ADDR_W-1:MEM_GRAN]),
    .hit(pfInRange)
  );

  // Legacy carve-outs
  logic              upperIoZero, upperMemZero, legacyIo;
  logic [ALIAS_W-1:0] alias10;
  logic              isaAlias, vgaIoHit, vgaMemHit, snoopHit;
  logic              ioClaim, memClaim, pfClaim, claim;

  always_comb begin
    upperIoZero  = (reqAddr[ADDR_W-1:IO_W] == '0);
    upperMemZero = (reqAddr[ADDR_W-1:MEM_W] == '0);
    legacyIo     = (reqAddr[ADDR_W-1:ISA_SPACE] == '0);
    alias10      = reqAddr[ALIAS_W-1:0];

    isaAlias  = isaEn && legacyIo && (reqAddr[9:8] != 2'b00);

    vgaIoHit  = vgaEn && strobes.isIo && legacyIo &&
                (((alias10 >= 10'h3B0) && (alias10 <= 10'h3BB)) ||
                 ((alias10 >= 10'h3C0) && (alias10 <= 10'h3DF)));
    vgaMemHit = vgaEn && strobes.isMem && (reqAddr[ADDR_W-1:17] == 'd5);

    snoopHit  = vgaSnoop && strobes.isIo && reqWrite && legacyIo &&
                ((alias10 == 10'h3C6) || (alias10 == 10'h3C8) ||
                 (alias10 == 10'h3C9));

    ioClaim  = strobes.isIo  && upperIoZero  && ioInRange && !isaAlias;
    memClaim = strobes.isMem && upperMemZero && memInRange;
    pfClaim  = strobes.isMem && pfInRange;

    claim = ioClaim || memClaim || pfClaim || vgaIoHit || vgaMemHit || snoopHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdDown <= 1'b0;
      fwdUp   <= 1'b0;
    end else if (strobes.reqLoad) begin
      fwdDown <= !fromSec && claim;
      fwdUp   <= fromSec && !claim && (strobes.isIo || strobes.isMem);
    end else begin
      fwdDown <= 1'b0;
      fwdUp   <= 1'b0;
    end
  end
endmodule

// File: rtl/pci_window_decode.sv
module pci_window_decode
  import pwd_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int IO_W     = 32,
  parameter int MEM_W    = 32,
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              reqWrite,
  input  logic              fromSec,
  output logic              fwdDown,
  output logic              fwdUp
);
  strobe_t strobes;

  pwd_ctrl u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .reqValid(reqValid),
    .reqKind (reqKind),
    .strobes (strobes)
  );

  pwd_datapath #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .MEM_W(MEM_W),
    .IO_GRAN(IO_GRAN), .MEM_GRAN(MEM_GRAN), .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgWrData(cfgWrData),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .fromSec  (fromSec),
    .fwdDown  (fwdDown),
    .fwdUp    (fwdUp)
  );
endmodule

// File: rtl/pwd_chk.sv
module pwd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqKind,
  input logic       fromSec,
  input logic       fwdDown,
  input logic       fwdUp
);
  // R10
  one_direction_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fwdDown, fwdUp}));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!fwdDown && !fwdUp));

  // R2
  no_class_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqKind == 2'd0 || reqKind == 2'd3)) |=> (!fwdDown && !fwdUp));

  // R10
  sec_never_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && fromSec) |=> !fwdDown);

  // R10
  pri_never_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !fromSec) |=> !fwdUp);

  // R1
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (!fwdDown && !fwdUp);
    end
  end
endmodule

bind pci_window_decode pwd_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqKind (reqKind),
  .fromSec (fromSec),
  .fwdDown (fwdDown),
  .fwdUp   (fwdUp)
);

// File: tb/pci_window_decode_tb.sv
module pci_window_decode_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqWrite = 1'b0;
  logic        fromSec = 1'b0;
  logic        fwdDown, fwdUp;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_window_decode u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqWrite(reqWrite), .fromSec(fromSec),
    .fwdDown(fwdDown), .fwdUp(fwdUp)
  );

  // Reference state, as full addresses
  logic [31:0] mIoBase, mIoLim, mMemBase, mMemLim;
  logic [63:0] mPfBase, mPfLim;
  logic        mIsa, mVga, mSnoop;

  task automatic modelReset();
    mIoBase = 32'hFFFF_F000; mIoLim = 32'h0000_0FFF;
    mMemBase = 32'hFFF0_0000; mMemLim = 32'h000F_FFFF;
    mPfBase = 64'hFFFF_FFFF_FFF0_0000; mPfLim = 64'h0000_0000_000F_FFFF;
    mIsa = 0; mVga = 0; mSnoop = 0;
  endtask

  task automatic modelWrite(input logic [2:0] s, input logic [31:0] d);
    case (s)
      3'd0: begin mIoBase[15:12] = d[7:4]; mIoLim[15:12] = d[15:12]; end
      3'd1: begin mIoBase[31:16] = d[15:0]; mIoLim[31:16] = d[31:16]; end
      3'd2: begin mMemBase[31:20] = d[15:4]; mMemLim[31:20] = d[31:20]; end
      3'd3: begin mPfBase[31:20] = d[15:4]; mPfLim[31:20] = d[31:20]; end
      3'd4: mPfBase[63:32] = d;
      3'd5: mPfLim[63:32] = d;
      3'd6: begin mIsa = d[0]; mVga = d[1]; mSnoop = d[2]; end
      default: ;
    endcase
  endtask

  function automatic logic [1:0] expectOut(input logic [63:0] a, input logic [1:0] k,
                                           input logic w, input logic sec);
    logic io, mem, low64k, cl;
    logic [9:0] a10;
    io = (k == 2'd1); mem = (k == 2'd2);
    low64k = (a < 64'h1_0000);
    a10 = a[9:0];
    cl = 0;
    if (io && a < 64'h1_0000_0000 && a[31:0] >= mIoBase && a[31:0] <= mIoLim &&
        !(mIsa && low64k && a[9:8] != 0)) cl = 1;
    if (mem && a < 64'h1_0000_0000 && a[31:0] >= mMemBase && a[31:0] <= mMemLim) cl = 1;
    if (mem && a >= mPfBase && a <= mPfLim) cl = 1;
    if (mVga && mem && a >= 64'hA0000 && a <= 64'hBFFFF) cl = 1;
    if (mVga && io && low64k &&
        ((a10 >= 10'h3B0 && a10 <= 10'h3BB) || (a10 >= 10'h3C0 && a10 <= 10'h3DF))) cl = 1;
    if (mSnoop && io && w && low64k &&
        (a10 == 10'h3C6 || a10 == 10'h3C8 || a10 == 10'h3C9)) cl = 1;
    expectOut[1] = !sec && cl;
    expectOut[0] = sec && !cl && (io || mem);
  endfunction

  task automatic check(input string tag, input logic [1:0] exp);
    nChecks++;
    if ({fwdDown, fwdUp} !== exp) begin
      nFails++;
      $display("FAIL %s: got down/up=%b%b expected %b%b", tag, fwdDown, fwdUp, exp[1], exp[0]);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = s; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
    modelWrite(s, d);
  endtask

  task automatic req(input string tag, input logic [63:0] a, input logic [1:0] k,
                     input logic w, input logic sec);
    logic [1:0] exp;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqKind = k; reqWrite = w; fromSec = sec;
    exp = expectOut(a, k, w, sec);
    @(negedge clk);
    reqValid = 0;
    check(tag, exp);
  endtask

  // Directed check with a hand-computed expectation as well
  task automatic reqExp(input string tag, input logic [63:0] a, input logic [1:0] k,
                        input logic w, input logic sec, input logic [1:0] hand);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqKind = k; reqWrite = w; fromSec = sec;
    @(negedge clk);
    reqValid = 0;
    check(tag, hand);
    nChecks++;
    if (expectOut(a, k, w, sec) !== hand) begin
      nFails++;
      $display("FAIL %s: model %b expected %b", tag, expectOut(a, k, w, sec), hand);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    modelReset();
    repeat (3) @(negedge clk);
    check("R1 outputs low in reset", 2'b00);
    rstN = 1;
    reqExp("R1 primary mem unclaimed", 64'h0, 2'd2, 0, 0, 2'b00);
    reqExp("R1 secondary io goes up", 64'h3000, 2'd1, 0, 1, 2'b01);
    @(negedge clk);
    check("R2 idle cycle quiet", 2'b00);
    reqExp("R2 class none quiet", 64'h0, 2'd0, 0, 1, 2'b00);
    reqExp("R2 class 3 quiet", 64'h0, 2'd3, 1, 0, 2'b00);

    // R3 I/O window 0x23000..0x24FFF, low nibbles set to prove they are ignored
    cfgWrite(3'd1, {16'h0002, 16'h0002});
    cfgWrite(3'd0, 32'h0000_4131);
    reqExp("R3 io base edge", 64'h2_3000, 2'd1, 0, 0, 2'b10);
    reqExp("R3 io limit edge", 64'h2_4FFF, 2'd1, 1, 0, 2'b10);
    reqExp("R3 io below base", 64'h2_2FFF, 2'd1, 0, 0, 2'b00);
    reqExp("R3 io above limit", 64'h2_5000, 2'd1, 0, 1, 2'b01);
    reqExp("R3 io upper bits set", 64'h1_0002_3000, 2'd1, 0, 0, 2'b00);

    // R4 memory window 0x12300000..0x124FFFFF
    cfgWrite(3'd2, {12'h124, 4'h0, 12'h123, 4'hF});
    reqExp("R4 mem base edge", 64'h1230_0000, 2'd2, 1, 0, 2'b10);
    reqExp("R4 mem limit edge", 64'h124F_FFFF, 2'd2, 0, 0, 2'b10);
    reqExp("R4 mem below", 64'h122F_FFFF, 2'd2, 0, 1, 2'b01);
    reqExp("R4 mem above", 64'h1250_0000, 2'd2, 0, 0, 2'b00);
    reqExp("R4 mem not 64-bit", 64'h1_1230_0000, 2'd2, 0, 0, 2'b00);
    reqExp("R10 secondary inside window stays", 64'h1240_0000, 2'd2, 0, 1, 2'b00);

    // R5 prefetchable 1_80000000..2_100FFFFF
    cfgWrite(3'd4, 32'h1);
    cfgWrite(3'd5, 32'h2);
    cfgWrite(3'd3, {12'h100, 4'h0, 12'h800, 4'h1});
    reqExp("R5 pf base above 4G", 64'h1_8000_0000, 2'd2, 0, 0, 2'b10);
    reqExp("R5 pf below base", 64'h1_7FFF_FFFF, 2'd2, 0, 0, 2'b00);
    reqExp("R5 pf limit edge", 64'h2_100F_FFFF, 2'd2, 0, 0, 2'b10);
    reqExp("R5 pf above limit", 64'h2_1010_0000, 2'd2, 0, 1, 2'b01);

    // R6 inverted memory window
    cfgWrite(3'd2, {12'h2FF, 4'h0, 12'h300, 4'h0});
    reqExp("R6 inverted at base", 64'h3000_0000, 2'd2, 0, 0, 2'b00);
    reqExp("R6 inverted at limit", 64'h2FF0_0000, 2'd2, 0, 1, 2'b01);

    // R7 ISA exclusion, I/O window 0..0x1FFFF
    cfgWrite(3'd1, {16'h0001, 16'h0000});
    cfgWrite(3'd0, 32'h0000_F000);
    reqExp("R7 no isa, 0x100 down", 64'h100, 2'd1, 0, 0, 2'b10);
    cfgWrite(3'd6, 32'h1);
    reqExp("R7 isa 0x100 not down", 64'h100, 2'd1, 0, 0, 2'b00);
    reqExp("R7 isa 0x100 goes up", 64'h100, 2'd1, 0, 1, 2'b01);
    reqExp("R7 isa 0x4FF bottom quarter", 64'h4FF, 2'd1, 0, 0, 2'b10);
    reqExp("R7 isa 0xFFFF top", 64'hFFFF, 2'd1, 0, 1, 2'b01);
    reqExp("R7 isa above 64K", 64'h1_0100, 2'd1, 0, 0, 2'b10);

    // R8 VGA, I/O window emptied, ISA still set
    cfgWrite(3'd0, 32'h0000_00F0);
    cfgWrite(3'd1, 32'h0000_FFFF);
    reqExp("R8 vga off A0000 up", 64'hA0000, 2'd2, 0, 1, 2'b01);
    cfgWrite(3'd6, 32'h3);
    reqExp("R8 vga A0000", 64'hA0000, 2'd2, 0, 0, 2'b10);
    reqExp("R8 vga BFFFF", 64'hBFFFF, 2'd2, 1, 0, 2'b10);
    reqExp("R8 vga 9FFFF", 64'h9FFFF, 2'd2, 0, 0, 2'b00);
    reqExp("R8 vga C0000 up", 64'hC0000, 2'd2, 0, 1, 2'b01);
    reqExp("R8 vga io 3B0 over isa", 64'h3B0, 2'd1, 0, 0, 2'b10);
    reqExp("R8 vga io 3BB", 64'h3BB, 2'd1, 0, 0, 2'b10);
    reqExp("R8 vga io 3BC", 64'h3BC, 2'd1, 0, 0, 2'b00);
    reqExp("R8 vga io 3DF", 64'h3DF, 2'd1, 0, 1, 2'b00);
    reqExp("R8 vga io 3E0 up", 64'h3E0, 2'd1, 0, 1, 2'b01);
    reqExp("R8 vga io alias 7B0", 64'h7B0, 2'd1, 0, 0, 2'b10);
    reqExp("R8 vga io above 64K", 64'h1_03B0, 2'd1, 0, 0, 2'b00);

    // R9 snoop only
    cfgWrite(3'd6, 32'h4);
    reqExp("R9 snoop write 3C6", 64'h3C6, 2'd1, 1, 0, 2'b10);
    reqExp("R9 snoop read 3C6", 64'h3C6, 2'd1, 0, 0, 2'b00);
    reqExp("R9 snoop write 3C7", 64'h3C7, 2'd1, 1, 0, 2'b00);
    reqExp("R9 snoop write 3C9", 64'h3C9, 2'd1, 1, 0, 2'b10);
    reqExp("R9 snoop alias C3C8", 64'hC3C8, 2'd1, 1, 0, 2'b10);
    reqExp("R9 snoop mem write", 64'h3C6, 2'd2, 1, 0, 2'b00);

    // R11 write and request in one cycle: memory window 0x40000000..0x40FFFFFF
    @(negedge clk);
    cfgWrEn = 1; cfgSel = 3'd2; cfgWrData = {12'h40F, 4'h0, 12'h400, 4'h0};
    reqValid = 1; reqAddr = 64'h4000_0000; reqKind = 2'd2; reqWrite = 0; fromSec = 0;
    @(negedge clk);
    cfgWrEn = 0; reqValid = 0;
    check("R11 same cycle uses old window", 2'b00);
    modelWrite(3'd2, {12'h40F, 4'h0, 12'h400, 4'h0});
    reqExp("R11 next request uses new window", 64'h4000_0000, 2'd2, 0, 0, 2'b10);

    // Constrained random
    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 0) begin
        cfgWrite(3'd0, $urandom);
        cfgWrite(3'd1, {16'($urandom % 4), 16'($urandom % 4)});
        cfgWrite(3'd2, $urandom);
        cfgWrite(3'd3, $urandom);
        cfgWrite(3'd4, $urandom % 3);
        cfgWrite(3'd5, $urandom % 3);
        cfgWrite(3'd6, $urandom % 8);
      end
      begin
        logic [63:0] a;
        case ($urandom % 4)
          0: a = {32'h0, 16'($urandom % 4), 16'($urandom)};
          1: a = {32'h0, 32'($urandom)};
          2: a = {32'($urandom % 3), 32'($urandom)};
          default: a = {44'h0, 20'($urandom)};
        endcase
        req("R10 random decision", a, 2'($urandom), 1'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule